// File: doc/BRIEF.md
# Free Buffer Pool Fetch Controller

This block sits between an AAL5 reassembly engine and a set of circular free-buffer tables held in a synchronous word memory. When the engine needs a fresh receive buffer, it raises a request that names a pool and says whether the buffer opens a new frame. Each pool has its own table region. The controller reads the pool's current entry and inspects the entry's flag bits. It then answers with exactly one outcome: a granted buffer pointer, a busy refusal, or a discard refusal.

An entry whose valid flag is clear stalls its pool. The stall stays in force until the host rewrites that pool's entry index. An entry carrying the interrupt flag is still handed out, but it also raises a sticky red-line status bit and an event pulse. A per-pool discard control refuses only requests that would open a new frame. Frames already under way keep receiving buffers, and the remaining requests of a refused frame are refused as well.

Requests may arrive every cycle. The outcome of the fetch still in flight is forwarded into the decision for the next request, so consecutive requests to the same pool take consecutive entries.

Top module: `fbp_fetch_ctrl`

## Requirements
- R1: A fetched entry with bit 31 (valid) clear is answered with a busy outcome and no pointer. The controller pulses `ev_got_busy` together with that response and sets the pool's busy status (bit 0 of its control register).
- R2: While a pool's busy status is set, every request to that pool is answered busy, with no table read and no `ev_got_busy` pulse. A host write to the pool's index register clears busy, loads the index, and service resumes from that entry.
- R3: A fetched entry with bit 29 (interrupt) set is still granted. The controller pulses `ev_redline` with the grant and sets the pool's red-line status (bit 1 of its control register).
- R4: With the pool's discard control (bit 8 of its control register) at 0, requests are served normally. With it at 1, a first-of-frame request is answered discard with no table read and no index change, while continuation requests of a frame whose first buffer was granted are still served.
- R5: Continuation requests that follow a discarded first-of-frame request are also answered discard, even if the discard control is cleared meanwhile. This lasts until the next first-of-frame request for that pool.
- R6: The table word address read is base register + pool × 16 + the pool's entry index.
- R7: After a grant, the pool's index advances by one. If the granted entry has bit 30 (wrap) set, the index returns to 0 instead.
- R8: Every request gets exactly one response, valid exactly two cycles after the request cycle, with exactly one of grant, busy or discard set.
- R9: After reset, the base register, every index, busy, red-line and discard bit are 0, and no response or table read is active.
- R10: In a control register write, a 1 in bit 0 or bit 1 clears that status bit and a 0 leaves it unchanged. Bit 8 takes the written value.
- R11: A granted pointer equals entry bits 28..2 placed at bits 28..2, with bits 31..29 and 1..0 zero.
- R12: Requests issued in consecutive cycles observe the result of the request before them. Grants take consecutive entries, and an invalid entry found by one request makes the next request to that pool busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Buffer request strobe |
| req_pool | input | PW | Pool number of the request |
| req_first | input | 1 | Request opens a new frame |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Outcome: pointer granted |
| rsp_busy | output | 1 | Outcome: pool busy |
| rsp_discard | output | 1 | Outcome: frame discarded |
| rsp_pool | output | PW | Pool of the response |
| rsp_ptr | output | 32 | Granted buffer pointer |
| mem_rd_en | output | 1 | Table read strobe |
| mem_addr | output | TA_W | Table word address |
| mem_rdata | input | 32 | Table data, one cycle after the read strobe |
| hwr_en | input | 1 | Host write strobe |
| hwr_addr | input | HA_W | Host write register address (0 base, 2p+2 control, 2p+3 index) |
| hwr_data | input | 32 | Host write data |
| hrd_addr | input | HA_W | Host read register address |
| hrd_data | output | 32 | Host read data (combinational) |
| ev_got_busy | output | 1 | Pulse: invalid entry fetched |
| ev_redline | output | 1 | Pulse: red-line entry granted |

## Verification
The assertions assume the table memory returns data exactly one cycle after a read strobe. They also assume a host write to a pool never lands in the same cycle as a fetch result for that pool, because the two sources have a fixed priority and the properties do not model it. The stimulus honours both assumptions. The bench memory model registers its read data on the strobe edge. Host writes are issued only while no request is in flight. Only the back-to-back test keeps requests in flight every cycle, and it does so with no host traffic.

// File: rtl/fbp_pkg.sv
// Package: shared constants and types of the free buffer pool fetch controller.
// Assumes 32-bit table entries and 32-bit host registers.
package fbp_pkg;
    localparam int ENT_VALID   = 31;
    localparam int ENT_WRAP    = 30;
    localparam int ENT_IRQ     = 29;
    localparam int ENT_PTR_MSB = 28;
    localparam int ENT_PTR_LSB = 2;

    localparam int CTL_BUSY = 0;
    localparam int CTL_RLI  = 1;
    localparam int CTL_EPD  = 8;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_FETCH = 2'd1,
        RK_BUSY  = 2'd2,
        RK_DROP  = 2'd3
    } req_kind_e;
endpackage

// File: rtl/fbp_pool_state.sv
// Module: per-pool state (entry index, busy, red-line, discard control, frame drop flag).
// Exposes "effective" index and busy that already include this cycle's fetch result,
// so a request in the same cycle sees it. Assumes host and fetch updates rarely collide;
// on collision the host index write wins over the index advance and clears busy.
module fbp_pool_state #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_idx_we,
    input  logic [IDX_W-1:0] host_idx_val,
    input  logic             host_ctl_we,
    input  logic             host_clr_busy,
    input  logic             host_clr_rli,
    input  logic             host_epd,
    input  logic             fet_adv,
    input  logic             fet_wrap,
    input  logic             fet_set_busy,
    input  logic             fet_set_rli,
    input  logic             fet_first,
    output logic [IDX_W-1:0] idx_q,
    output logic             busy_q,
    output logic             rli_q,
    output logic             epd_q,
    output logic             drop_q,
    output logic [IDX_W-1:0] eff_idx,
    output logic             eff_busy
);
    // Forwarded view of index and busy including the fetch result of this cycle.
    always_comb begin
        eff_idx  = idx_q;
        if (fet_adv) begin
            eff_idx = fet_wrap ? '0 : idx_q + 1'b1;
        end
        eff_busy = busy_q | fet_set_busy;
    end

    // Entry index: host write loads it, otherwise follows the forwarded value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (host_idx_we) begin
            idx_q <= host_idx_val;
        end else begin
            idx_q <= eff_idx;
        end
    end

    // Busy: set by an invalid entry, cleared by index write or write-one-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (host_idx_we) begin
            busy_q <= 1'b0;
        end else if (fet_set_busy) begin
            busy_q <= 1'b1;
        end else if (host_ctl_we && host_clr_busy) begin
            busy_q <= 1'b0;
        end
    end

    // Red-line status: set on a flagged grant, cleared by write-one-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rli_q <= 1'b0;
        end else if (fet_set_rli) begin
            rli_q <= 1'b1;
        end else if (host_ctl_we && host_clr_rli) begin
            rli_q <= 1'b0;
        end
    end

    // Discard control: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epd_q <= 1'b0;
        end else if (host_ctl_we) begin
            epd_q <= host_epd;
        end
    end

    // Frame drop flag: latched from the discard control at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_q <= 1'b0;
        end else if (fet_first) begin
            drop_q <= epd_q;
        end
    end
endmodule

// File: rtl/fbp_hostif.sv
// Module: host register decode and read mux.
// Map: 0 = table base, 2p+2 = pool p control/status, 2p+3 = pool p entry index.
// Assumes reads are combinational and unmapped addresses read as zero.
module fbp_hostif #(
    parameter int NUM_POOLS = 4,
    parameter int IDX_W     = 4,
    parameter int TA_W      = 10,
    parameter int HA_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hwr_en,
    input  logic [HA_W-1:0]            hwr_addr,
    input  logic [31:0]                hwr_data,
    input  logic [HA_W-1:0]            hrd_addr,
    input  logic [NUM_POOLS*IDX_W-1:0] pool_idx,
    input  logic [NUM_POOLS-1:0]       pool_busy,
    input  logic [NUM_POOLS-1:0]       pool_rli,
    input  logic [NUM_POOLS-1:0]       pool_epd,
    output logic [TA_W-1:0]            base_q,
    output logic [NUM_POOLS-1:0]       idx_we,
    output logic [NUM_POOLS-1:0]       ctl_we,
    output logic [31:0]                hrd_data
);
    import fbp_pkg::*;

    logic unused_hi;
    assign unused_hi = ^hwr_data[31:TA_W];

    // Table base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (hwr_en && hwr_addr == '0) begin
            base_q <= hwr_data[TA_W-1:0];
        end
    end

    // Per-pool write strobes.
    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_dec
        assign ctl_we[p] = hwr_en && (hwr_addr == HA_W'(2*p+2));
        assign idx_we[p] = hwr_en && (hwr_addr == HA_W'(2*p+3));
    end

    // Read mux over all registers.
    always_comb begin
        hrd_data = '0;
        if (hrd_addr == '0) begin
            hrd_data = {{(32-TA_W){1'b0}}, base_q};
        end
        for (int p = 0; p < NUM_POOLS; p++) begin
            if (hrd_addr == HA_W'(2*p+2)) begin
                hrd_data[CTL_BUSY] = pool_busy[p];
                hrd_data[CTL_RLI]  = pool_rli[p];
                hrd_data[CTL_EPD]  = pool_epd[p];
            end
            if (hrd_addr == HA_W'(2*p+3)) begin
                hrd_data = {{(32-IDX_W){1'b0}}, pool_idx[p*IDX_W +: IDX_W]};
            end
        end
    end
endmodule

// File: rtl/fbp_fetch.sv
// Module: request decision, table read and response pipeline.
// Stage 0 (request cycle) decides busy/discard/fetch and drives the table read.
// Stage 1 evaluates the returned entry and emits per-pool update strobes.
// Stage 2 registers the response. Assumes memory data one cycle after the strobe.
module fbp_fetch #(
    parameter int NUM_POOLS = 4,
    parameter int IDX_W     = 4,
    parameter int TA_W      = 10,
    parameter int PW        = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [PW-1:0]              req_pool,
    input  logic                       req_first,
    input  logic [TA_W-1:0]            base_q,
    input  logic [NUM_POOLS*IDX_W-1:0] eff_idx,
    input  logic [NUM_POOLS-1:0]       eff_busy,
    input  logic [NUM_POOLS-1:0]       pool_epd,
    input  logic [NUM_POOLS-1:0]       pool_drop,
    input  logic [31:0]                mem_rdata,
    output logic                       mem_rd_en,
    output logic [TA_W-1:0]            mem_addr,
    output logic [NUM_POOLS-1:0]       fet_adv,
    output logic                       fet_wrap,
    output logic [NUM_POOLS-1:0]       fet_set_busy,
    output logic [NUM_POOLS-1:0]       fet_set_rli,
    output logic [NUM_POOLS-1:0]       fet_first,
    output logic                       rsp_valid,
    output logic                       rsp_grant,
    output logic                       rsp_busy,
    output logic                       rsp_discard,
    output logic [PW-1:0]              rsp_pool,
    output logic [31:0]                rsp_ptr,
    output logic                       ev_got_busy,
    output logic                       ev_redline
);
    import fbp_pkg::*;

    req_kind_e        kind0, s1_kind;
    logic [PW-1:0]    s1_pool;
    logic [IDX_W-1:0] sel_idx;
    logic             drop0, grant1, stall1, irq1;
    logic             unused_lo;

    assign unused_lo = ^mem_rdata[ENT_PTR_LSB-1:0];

    // Stage 0: classify the request using the forwarded pool state.
    always_comb begin
        sel_idx = eff_idx[req_pool*IDX_W +: IDX_W];
        drop0   = req_first ? pool_epd[req_pool] : pool_drop[req_pool];
        if (!req_valid) begin
            kind0 = RK_NONE;
        end else if (eff_busy[req_pool]) begin
            kind0 = RK_BUSY;
        end else if (drop0) begin
            kind0 = RK_DROP;
        end else begin
            kind0 = RK_FETCH;
        end
        mem_rd_en = (kind0 == RK_FETCH);
        mem_addr  = base_q + (TA_W'(req_pool) << IDX_W) + TA_W'(sel_idx);
    end

    // Stage 1 register: remember what was decided and for which pool.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_kind <= RK_NONE;
            s1_pool <= '0;
        end else begin
            s1_kind <= kind0;
            s1_pool <= req_pool;
        end
    end

    // Stage 1: evaluate the returned entry and build per-pool strobes.
    always_comb begin
        grant1   = (s1_kind == RK_FETCH) && mem_rdata[ENT_VALID];
        stall1   = (s1_kind == RK_FETCH) && !mem_rdata[ENT_VALID];
        irq1     = grant1 && mem_rdata[ENT_IRQ];
        fet_wrap = mem_rdata[ENT_WRAP];
        for (int p = 0; p < NUM_POOLS; p++) begin
            fet_adv[p]      = grant1 && (s1_pool == PW'(p));
            fet_set_busy[p] = stall1 && (s1_pool == PW'(p));
            fet_set_rli[p]  = irq1 && (s1_pool == PW'(p));
            fet_first[p]    = req_valid && req_first && (req_pool == PW'(p));
        end
    end

    // Stage 2: register the single response and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_grant   <= 1'b0;
            rsp_busy    <= 1'b0;
            rsp_discard <= 1'b0;
            rsp_pool    <= '0;
            rsp_ptr     <= '0;
            ev_got_busy <= 1'b0;
            ev_redline  <= 1'b0;
        end else begin
            rsp_valid   <= (s1_kind != RK_NONE);
            rsp_grant   <= grant1;
            rsp_busy    <= stall1 || (s1_kind == RK_BUSY);
            rsp_discard <= (s1_kind == RK_DROP);
            rsp_pool    <= s1_pool;
            rsp_ptr     <= grant1 ? {3'b000, mem_rdata[ENT_PTR_MSB:ENT_PTR_LSB], 2'b00} : '0;
            ev_got_busy <= stall1;
            ev_redline  <= irq1;
        end
    end
endmodule

// File: rtl/fbp_fetch_ctrl.sv
// Module: top of the free buffer pool fetch controller.
// Wires host register decode, one state slice per pool and the fetch pipeline.
// Assumes a single-cycle synchronous table memory outside this block.
module fbp_fetch_ctrl #(
    parameter int NUM_POOLS = 4,
    parameter int IDX_W     = 4,
    parameter int TA_W      = 10,
    localparam int PW       = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
    localparam int HA_W     = $clog2(2*NUM_POOLS+2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [PW-1:0]   req_pool,
    input  logic            req_first,
    output logic            rsp_valid,
    output logic            rsp_grant,
    output logic            rsp_busy,
    output logic            rsp_discard,
    output logic [PW-1:0]   rsp_pool,
    output logic [31:0]     rsp_ptr,
    output logic            mem_rd_en,
    output logic [TA_W-1:0] mem_addr,
    input  logic [31:0]     mem_rdata,
    input  logic            hwr_en,
    input  logic [HA_W-1:0] hwr_addr,
    input  logic [31:0]     hwr_data,
    input  logic [HA_W-1:0] hrd_addr,
    output logic [31:0]     hrd_data,
    output logic            ev_got_busy,
    output logic            ev_redline
);
    import fbp_pkg::*;

    logic [TA_W-1:0]            base_q;
    logic [NUM_POOLS*IDX_W-1:0] pool_idx, eff_idx;
    logic [NUM_POOLS-1:0]       pool_busy, pool_rli, pool_epd, pool_drop, eff_busy;
    logic [NUM_POOLS-1:0]       idx_we, ctl_we;
    logic [NUM_POOLS-1:0]       fet_adv, fet_set_busy, fet_set_rli, fet_first;
    logic                       fet_wrap;

    fbp_hostif #(.NUM_POOLS(NUM_POOLS), .IDX_W(IDX_W), .TA_W(TA_W), .HA_W(HA_W)) u_host (
        .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .hwr_addr(hwr_addr),
        .hwr_data(hwr_data), .hrd_addr(hrd_addr), .pool_idx(pool_idx),
        .pool_busy(pool_busy), .pool_rli(pool_rli), .pool_epd(pool_epd),
        .base_q(base_q), .idx_we(idx_we), .ctl_we(ctl_we), .hrd_data(hrd_data)
    );

    for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
        fbp_pool_state #(.IDX_W(IDX_W)) u_state (
            .clk(clk), .rst_n(rst_n),
            .host_idx_we(idx_we[p]), .host_idx_val(hwr_data[IDX_W-1:0]),
            .host_ctl_we(ctl_we[p]), .host_clr_busy(hwr_data[CTL_BUSY]),
            .host_clr_rli(hwr_data[CTL_RLI]), .host_epd(hwr_data[CTL_EPD]),
            .fet_adv(fet_adv[p]), .fet_wrap(fet_wrap),
            .fet_set_busy(fet_set_busy[p]), .fet_set_rli(fet_set_rli[p]),
            .fet_first(fet_first[p]),
            .idx_q(pool_idx[p*IDX_W +: IDX_W]), .busy_q(pool_busy[p]),
            .rli_q(pool_rli[p]), .epd_q(pool_epd[p]), .drop_q(pool_drop[p]),
            .eff_idx(eff_idx[p*IDX_W +: IDX_W]), .eff_busy(eff_busy[p])
        );
    end

    fbp_fetch #(.NUM_POOLS(NUM_POOLS), .IDX_W(IDX_W), .TA_W(TA_W), .PW(PW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pool(req_pool),
        .req_first(req_first), .base_q(base_q), .eff_idx(eff_idx),
        .eff_busy(eff_busy), .pool_epd(pool_epd), .pool_drop(pool_drop),
        .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .fet_adv(fet_adv), .fet_wrap(fet_wrap), .fet_set_busy(fet_set_busy),
        .fet_set_rli(fet_set_rli), .fet_first(fet_first),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_busy(rsp_busy),
        .rsp_discard(rsp_discard), .rsp_pool(rsp_pool), .rsp_ptr(rsp_ptr),
        .ev_got_busy(ev_got_busy), .ev_redline(ev_redline)
    );
endmodule

// File: rtl/fbp_checker.sv
// Module: protocol checker bound to the fetch controller top.
// Assumes memory data one cycle after a read strobe and no host write colliding
// with a fetch result of the same pool.
module fbp_checker #(
    parameter int NUM_POOLS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_grant,
    input logic                 rsp_busy,
    input logic                 rsp_discard,
    input logic                 mem_rd_en,
    input logic                 hwr_en,
    input logic                 ev_got_busy,
    input logic                 ev_redline,
    input logic [NUM_POOLS-1:0] pool_busy
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_busy, rsp_discard}) == 1); // R8
    AST_NO_STRAY_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_grant || rsp_busy || rsp_discard)); // R8
    AST_TWO_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid); // R8
    AST_GOTBUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_got_busy |-> (rsp_busy && !rsp_grant)); // R1
    AST_REDLINE_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_redline |-> rsp_grant); // R3
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(pool_busy) & ~pool_busy)) |-> $past(hwr_en)); // R2
    AST_READ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> req_valid); // R4
endmodule

bind fbp_fetch_ctrl fbp_checker #(.NUM_POOLS(NUM_POOLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_busy(rsp_busy), .rsp_discard(rsp_discard),
    .mem_rd_en(mem_rd_en), .hwr_en(hwr_en), .ev_got_busy(ev_got_busy),
    .ev_redline(ev_redline), .pool_busy(pool_busy)
);

// File: tb/sim_fbp_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_fbp_fetch_ctrl;
    localparam int NP = 4;
    localparam int IW = 4;
    localparam int TW = 10;
    localparam int PW = 2;
    localparam int HW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_pool = '0;
    logic          req_first = 1'b0;
    logic          rsp_valid, rsp_grant, rsp_busy, rsp_discard;
    logic [PW-1:0] rsp_pool;
    logic [31:0]   rsp_ptr;
    logic          mem_rd_en;
    logic [TW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          hwr_en = 1'b0;
    logic [HW-1:0] hwr_addr = '0;
    logic [31:0]   hwr_data = '0;
    logic [HW-1:0] hrd_addr = '0;
    logic [31:0]   hrd_data;
    logic          ev_got_busy, ev_redline;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    logic [TW-1:0] last_addr = '0;
    logic [31:0] tbl [0:(1<<TW)-1];

    always #2 clk = ~clk;

    fbp_fetch_ctrl #(.NUM_POOLS(NP), .IDX_W(IW), .TA_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pool(req_pool),
        .req_first(req_first), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_busy(rsp_busy), .rsp_discard(rsp_discard), .rsp_pool(rsp_pool),
        .rsp_ptr(rsp_ptr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .hwr_en(hwr_en), .hwr_addr(hwr_addr),
        .hwr_data(hwr_data), .hrd_addr(hrd_addr), .hrd_data(hrd_data),
        .ev_got_busy(ev_got_busy), .ev_redline(ev_redline)
    );

    // Table memory model: one-cycle synchronous read.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= tbl[mem_addr];
            last_addr <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    // Vector: {pool[2], first, kind[2] (1 grant 2 busy 3 discard), ptr[32], redline, gotbusy}
    localparam logic [38:0] VEC [0:6] = '{
        {2'd0, 1'b1, 2'd1, 32'h0000_1000, 1'b0, 1'b0},
        {2'd0, 1'b0, 2'd1, 32'h0000_2000, 1'b1, 1'b0},
        {2'd0, 1'b0, 2'd1, 32'h0000_3000, 1'b0, 1'b0},
        {2'd0, 1'b1, 2'd1, 32'h0000_1000, 1'b0, 1'b0},
        {2'd1, 1'b1, 2'd1, 32'h0000_4000, 1'b0, 1'b0},
        {2'd1, 1'b0, 2'd2, 32'h0000_0000, 1'b0, 1'b1},
        {2'd1, 1'b0, 2'd2, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [HW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        hwr_en = 1'b1; hwr_addr = a; hwr_data = d;
        @(negedge clk);
        hwr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [HW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        hrd_addr = a;
        #1 d = hrd_data;
    endtask

    function automatic logic [1:0] cur_kind();
        if (!rsp_valid) return 2'd0;
        if (rsp_grant) return 2'd1;
        if (rsp_busy) return 2'd2;
        if (rsp_discard) return 2'd3;
        return 2'd0;
    endfunction

    task automatic do_req(input logic [PW-1:0] p, input bit f, output logic [1:0] k,
                          output logic [31:0] ptr, output bit rl, output bit eb);
        @(negedge clk);
        req_valid = 1'b1; req_pool = p; req_first = f;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R8 response one cycle early", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        k = cur_kind(); ptr = rsp_ptr; rl = ev_redline; eb = ev_got_busy;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]  k;
        logic [31:0] ptr, d;
        bit          rl, eb;
        int          rd0;
        for (int i = 0; i < (1<<TW); i++) tbl[i] = '0;
        tbl[10'h100] = 32'h8000_1003;
        tbl[10'h101] = 32'hA000_2000;
        tbl[10'h102] = 32'hC000_3000;
        tbl[10'h110] = 32'h8000_4000;
        tbl[10'h111] = 32'h0000_5000;
        tbl[10'h223] = 32'h8000_5004;
        tbl[10'h230] = 32'h8000_6000;
        tbl[10'h231] = 32'h8000_7000;
        tbl[10'h232] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        chk(rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R9 outputs idle", 32'(rsp_valid), 32'd0);
        host_rd(4'd0, d); chk(d == 32'd0, "R9 base reset", d, 32'd0);
        host_rd(4'd2, d); chk(d == 32'd0, "R9 pool0 control reset", d, 32'd0);
        host_rd(4'd5, d); chk(d == 32'd0, "R9 pool1 index reset", d, 32'd0);

        host_wr(4'd0, 32'h100);

        // Vector walk: R1/R3/R7/R11 main function
        for (int i = 0; i < 7; i++) begin
            logic [38:0] v;
            v = VEC[i];
            do_req(v[38:37], v[36], k, ptr, rl, eb);
            chk(k == v[35:34], $sformatf("R1/R3/R7 vector %0d kind", i), 32'(k), 32'(v[35:34]));
            chk(ptr == v[33:2], $sformatf("R7/R11 vector %0d pointer", i), ptr, v[33:2]);
            chk(rl == v[1], $sformatf("R3 vector %0d redline event", i), 32'(rl), 32'(v[1]));
            chk(eb == v[0], $sformatf("R1 vector %0d busy event", i), 32'(eb), 32'(v[0]));
            if (i == 0) chk(last_addr == 10'h100, "R6 first address", 32'(last_addr), 32'h100);
        end

        host_rd(4'd4, d); chk(d[0] == 1'b1, "R1 pool1 busy status", d, 32'h1);
        host_rd(4'd2, d); chk(d[1] == 1'b1, "R3 pool0 redline status", d, 32'h2);

        // R10: write-one-clear
        host_wr(4'd2, 32'h0);
        host_rd(4'd2, d); chk(d == 32'h2, "R10 zero write keeps status", d, 32'h2);
        host_wr(4'd2, 32'h2);
        host_rd(4'd2, d); chk(d == 32'h0, "R10 one write clears status", d, 32'h0);

        // R2: stalled pool refuses without reading, index write resumes
        rd0 = rd_cnt;
        do_req(2'd1, 1'b1, k, ptr, rl, eb);
        chk(k == 2'd2 && eb == 1'b0, "R2 stalled pool busy without event", {k, 29'd0, eb}, {2'd2, 30'd0});
        chk(rd_cnt == rd0, "R2 no table read while busy", rd_cnt, rd0);
        host_wr(4'd5, 32'h0);
        host_rd(4'd4, d); chk(d[0] == 1'b0, "R2 index write clears busy", d, 32'h0);
        do_req(2'd1, 1'b1, k, ptr, rl, eb);
        chk(k == 2'd1 && ptr == 32'h4000, "R2 service resumes", ptr, 32'h4000);

        // R4/R5: discard control
        do_req(2'd0, 1'b1, k, ptr, rl, eb);
        chk(k == 2'd1 && ptr == 32'h2000, "R4 normal frame start", ptr, 32'h2000);
        host_wr(4'd2, 32'h100);
        do_req(2'd0, 1'b0, k, ptr, rl, eb);
        chk(k == 2'd1 && ptr == 32'h3000, "R4 frame in progress still served", ptr, 32'h3000);
        rd0 = rd_cnt;
        do_req(2'd0, 1'b1, k, ptr, rl, eb);
        chk(k == 2'd3, "R4 new frame discarded", 32'(k), 32'd3);
        chk(rd_cnt == rd0, "R4 no table read on discard", rd_cnt, rd0);
        do_req(2'd0, 1'b0, k, ptr, rl, eb);
        chk(k == 2'd3, "R5 continuation of dropped frame", 32'(k), 32'd3);
        host_wr(4'd2, 32'h0);
        do_req(2'd0, 1'b0, k, ptr, rl, eb);
        chk(k == 2'd3, "R5 drop persists after control cleared", 32'(k), 32'd3);
        do_req(2'd0, 1'b1, k, ptr, rl, eb);
        chk(k == 2'd1 && ptr == 32'h1000, "R4/R7 index kept by discards", ptr, 32'h1000);
        host_rd(4'd3, d); chk(d == 32'd1, "R7 index advanced after grant", d, 32'd1);

        // R6: address composition with new base and loaded index
        host_wr(4'd0, 32'h200);
        host_wr(4'd7, 32'h3);
        do_req(2'd2, 1'b1, k, ptr, rl, eb);
        chk(last_addr == 10'h223, "R6 base plus pool times 16 plus index", 32'(last_addr), 32'h223);
        chk(k == 2'd1 && ptr == 32'h5004, "R11 pointer bits", ptr, 32'h5004);

        // R12: back-to-back requests on pool 3
        for (int i = 0; i < 6; i++) begin
            logic [1:0]  ek;
            logic [31:0] ep;
            bit          eeb;
            @(negedge clk);
            if (i >= 2) begin
                ek  = (i < 4) ? 2'd1 : 2'd2;
                ep  = (i == 2) ? 32'h6000 : (i == 3) ? 32'h7000 : 32'h0;
                eeb = (i == 4);
                chk(cur_kind() == ek, $sformatf("R12 back-to-back kind %0d", i-2), 32'(cur_kind()), 32'(ek));
                chk(rsp_ptr == ep, $sformatf("R12 back-to-back pointer %0d", i-2), rsp_ptr, ep);
                chk(ev_got_busy == eeb, $sformatf("R12 back-to-back busy event %0d", i-2), 32'(ev_got_busy), 32'(eeb));
            end else begin
                chk(rsp_valid == 1'b0, "R8 no response before two cycles", 32'(rsp_valid), 32'd0);
            end
            if (i < 4) begin
                req_valid = 1'b1; req_pool = 2'd3; req_first = (i == 0);
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 no extra response", 32'(rsp_valid), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule